// File: doc/BRIEF.md
# Cascaded Next-Stream Predictor

This block sits at the head of an instruction fetch front end and predicts one stream per lookup. A stream is a sequential run of instructions that ends at a taken branch. Branches inside a stream are treated as not taken, so no per-branch direction state is kept. One lookup yields a hit flag, the stream length, the type of the terminating branch and the start address of the following stream. The block takes the place of both a branch direction predictor and a branch target buffer.

There are two direct-mapped tables. Each entry has a valid bit, the full start address as a tag, the length, the branch type, the next start address and a 2-bit hysteresis counter. The address table is indexed by fetch address bits above the instruction offset. The path table is indexed by a path hash, which the caller builds from the current address and the preceding stream starts. Lookup is combinational.

Completed streams arrive at commit on the update port, together with a flag that says whether the stream was mispredicted. The counter rules let overlapping streams that share a start address displace each other only after repeated disagreement. On a miss the caller fetches sequentially.

Top module: `stream_pred`

## Requirements
- R1: After reset every entry of both tables is invalid, so every lookup misses.
- R2: When neither table holds a matching tag, pred_hit_o is 0 and pred_src_o, pred_len_o, pred_type_o and pred_next_o are all 0.
- R3: An update whose start address matches in neither table writes the stream into both tables with its counter set to 1. A following lookup at that address then hits through either index.
- R4: When both tables hit, the path table supplies the prediction and pred_src_o is 1. When only the address table hits, it supplies the prediction and pred_src_o is 0.
- R5: An entry hits only if its stored tag equals the full lookup address. A different address that maps to the same slot misses.
- R6: On a tag hit, an update whose length and next address both agree increments the counter, saturating at 3. Any disagreement decrements the counter while it is above 1. At 1, the entry's length, type and next address are replaced and the counter is set to 1. From saturation, the third consecutive disagreement replaces the entry.
- R7: An update that hits only in the path table trains only that table. The address-table slot keeps its current contents.
- R8: An update that hits only in the address table trains it. With upd_mispred_i = 1 the stream is also written into the path-table slot with counter 1. With upd_mispred_i = 0 the path table is unchanged.
- R9: A lookup made in the same cycle as an update to the same entry returns the contents from before the update. The new contents appear after the clock edge.
- R10: While upd_valid_i is 0 the update fields have no effect on either table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_addr_i | input | ADDR_W | Current fetch address to look up |
| lk_hash_i | input | T2_IDX_W | Path hash index for the path table |
| pred_hit_o | output | 1 | A table holds the stream |
| pred_src_o | output | 1 | 1 = path table supplied, 0 = address table |
| pred_len_o | output | LEN_W | Predicted stream length in instructions |
| pred_type_o | output | TYPE_W | Type of the terminating branch |
| pred_next_o | output | ADDR_W | Predicted start of the next stream |
| upd_valid_i | input | 1 | Commit update strobe |
| upd_addr_i | input | ADDR_W | Start address of the committed stream |
| upd_hash_i | input | T2_IDX_W | Path hash used when the stream was fetched |
| upd_len_i | input | LEN_W | Committed stream length |
| upd_type_i | input | TYPE_W | Committed terminating branch type |
| upd_next_i | input | ADDR_W | Committed next stream start |
| upd_mispred_i | input | 1 | The stream was mispredicted |

## Verification
The bench walks the counter from allocation through saturation and then applies repeated disagreeing updates. A counter that wrapped, failed to saturate or replaced the entry too early would show the new length one or two updates too soon. A second case evicts a stream from the address table and then updates it through the path table only. A design that wrote both tables there would destroy the evicting stream. Further cases cover address-table-only hits with and without the mispredict flag, where a wrong design would allocate into the path table without cause or never allocate. A same-cycle lookup and update checks that the old entry is still shown until the clock edge.

// File: rtl/stream_pred_pkg.sv
package stream_pred_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_INIT = 2'd1;

  function automatic ctr_t ctr_up(input ctr_t c);
    return (c == CTR_MAX) ? c : c + 2'd1;
  endfunction

  function automatic ctr_t ctr_down(input ctr_t c);
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/stream_pred_table.sv
module stream_pred_table
  import stream_pred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 6,
  parameter int TYPE_W = 2,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_tag_o,
  output logic [LEN_W-1:0]  rd_len_o,
  output logic [TYPE_W-1:0] rd_type_o,
  output logic [ADDR_W-1:0] rd_next_o,
  input  logic [IDX_W-1:0]  up_idx_i,
  output logic              up_valid_o,
  output logic [ADDR_W-1:0] up_tag_o,
  output logic [LEN_W-1:0]  up_len_o,
  output logic [TYPE_W-1:0] up_type_o,
  output logic [ADDR_W-1:0] up_next_o,
  output ctr_t              up_ctr_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_tag_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic [TYPE_W-1:0] wr_type_i,
  input  logic [ADDR_W-1:0] wr_next_i,
  input  ctr_t              wr_ctr_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic              valid_q [DEPTH];
  ctr_t              ctr_q   [DEPTH];
  logic [ADDR_W-1:0] tag_q   [DEPTH];
  logic [LEN_W-1:0]  len_q   [DEPTH];
  logic [TYPE_W-1:0] type_q  [DEPTH];
  logic [ADDR_W-1:0] next_q  [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        valid_q[i] <= 1'b0;
        ctr_q[i]   <= '0;
      end
    end else if (wr_en_i) begin
      valid_q[up_idx_i] <= 1'b1;
      ctr_q[up_idx_i]   <= wr_ctr_i;
    end
  end

  // payload needs no reset: gated by valid
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[up_idx_i]  <= wr_tag_i;
      len_q[up_idx_i]  <= wr_len_i;
      type_q[up_idx_i] <= wr_type_i;
      next_q[up_idx_i] <= wr_next_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_len_o   = len_q[rd_idx_i];
  assign rd_type_o  = type_q[rd_idx_i];
  assign rd_next_o  = next_q[rd_idx_i];

  assign up_valid_o = valid_q[up_idx_i];
  assign up_tag_o   = tag_q[up_idx_i];
  assign up_len_o   = len_q[up_idx_i];
  assign up_type_o  = type_q[up_idx_i];
  assign up_next_o  = next_q[up_idx_i];
  assign up_ctr_o   = ctr_q[up_idx_i];
endmodule

// File: rtl/stream_pred_sel.sv
module stream_pred_sel #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 6,
  parameter int TYPE_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              a_valid_i,
  input  logic [ADDR_W-1:0] a_tag_i,
  input  logic [LEN_W-1:0]  a_len_i,
  input  logic [TYPE_W-1:0] a_type_i,
  input  logic [ADDR_W-1:0] a_next_i,
  input  logic              p_valid_i,
  input  logic [ADDR_W-1:0] p_tag_i,
  input  logic [LEN_W-1:0]  p_len_i,
  input  logic [TYPE_W-1:0] p_type_i,
  input  logic [ADDR_W-1:0] p_next_i,
  output logic              hit_o,
  output logic              src_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [TYPE_W-1:0] type_o,
  output logic [ADDR_W-1:0] next_o
);
  logic a_hit, p_hit;
  assign a_hit = a_valid_i && (a_tag_i == addr_i);
  assign p_hit = p_valid_i && (p_tag_i == addr_i);

  always_comb begin
    hit_o  = 1'b0;
    src_o  = 1'b0;
    len_o  = '0;
    type_o = '0;
    next_o = '0;
    if (p_hit) begin
      hit_o  = 1'b1;
      src_o  = 1'b1;
      len_o  = p_len_i;
      type_o = p_type_i;
      next_o = p_next_i;
    end else if (a_hit) begin
      hit_o  = 1'b1;
      len_o  = a_len_i;
      type_o = a_type_i;
      next_o = a_next_i;
    end
  end
endmodule

// File: rtl/stream_pred_upd.sv
module stream_pred_upd
  import stream_pred_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 6,
  parameter int TYPE_W = 2,
  parameter int NTAB   = 2
) (
  input  logic              valid_i,
  input  logic              mispred_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [ADDR_W-1:0] next_i,
  input  logic              st_valid_i [NTAB],
  input  logic [ADDR_W-1:0] st_tag_i   [NTAB],
  input  logic [LEN_W-1:0]  st_len_i   [NTAB],
  input  logic [TYPE_W-1:0] st_type_i  [NTAB],
  input  logic [ADDR_W-1:0] st_next_i  [NTAB],
  input  ctr_t              st_ctr_i   [NTAB],
  output logic              wr_en_o    [NTAB],
  output logic [LEN_W-1:0]  wr_len_o   [NTAB],
  output logic [TYPE_W-1:0] wr_type_o  [NTAB],
  output logic [ADDR_W-1:0] wr_next_o  [NTAB],
  output ctr_t              wr_ctr_o   [NTAB]
);
  // table 0 = address table, table 1 = path table
  logic hit   [NTAB];
  logic alloc [NTAB];
  logic fresh;

  for (genvar g = 0; g < NTAB; g++) begin : g_hit
    assign hit[g] = st_valid_i[g] && (st_tag_i[g] == addr_i);
  end

  always_comb begin
    fresh = 1'b1;
    for (int i = 0; i < NTAB; i++) fresh = fresh && !hit[i];
  end

  for (genvar g = 0; g < NTAB; g++) begin : g_train
    if (g == 0) begin : g_addr
      assign alloc[g] = fresh;
    end else begin : g_path
      assign alloc[g] = fresh || (hit[0] && !hit[g] && mispred_i);
    end

    logic agree, keep;
    assign agree = (st_len_i[g] == len_i) && (st_next_i[g] == next_i);
    assign keep  = hit[g] && (agree || (st_ctr_i[g] > CTR_INIT));

    always_comb begin
      wr_en_o[g] = valid_i && (hit[g] || alloc[g]);
      if (keep) begin
        wr_len_o[g]  = st_len_i[g];
        wr_type_o[g] = st_type_i[g];
        wr_next_o[g] = st_next_i[g];
        wr_ctr_o[g]  = agree ? ctr_up(st_ctr_i[g]) : ctr_down(st_ctr_i[g]);
      end else begin
        wr_len_o[g]  = len_i;
        wr_type_o[g] = type_i;
        wr_next_o[g] = next_i;
        wr_ctr_o[g]  = CTR_INIT;
      end
    end
  end
endmodule

// File: rtl/stream_pred.sv
module stream_pred
  import stream_pred_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 6,
  parameter int TYPE_W   = 2,
  parameter int OFF_W    = 2,
  parameter int T1_IDX_W = 6,
  parameter int T2_IDX_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   lk_addr_i,
  input  logic [T2_IDX_W-1:0] lk_hash_i,
  output logic                pred_hit_o,
  output logic                pred_src_o,
  output logic [LEN_W-1:0]    pred_len_o,
  output logic [TYPE_W-1:0]   pred_type_o,
  output logic [ADDR_W-1:0]   pred_next_o,
  input  logic                upd_valid_i,
  input  logic [ADDR_W-1:0]   upd_addr_i,
  input  logic [T2_IDX_W-1:0] upd_hash_i,
  input  logic [LEN_W-1:0]    upd_len_i,
  input  logic [TYPE_W-1:0]   upd_type_i,
  input  logic [ADDR_W-1:0]   upd_next_i,
  input  logic                upd_mispred_i
);
  localparam int NTAB = 2;

  logic [T1_IDX_W-1:0] lk_idx1, up_idx1;
  assign lk_idx1 = lk_addr_i[OFF_W +: T1_IDX_W];
  assign up_idx1 = upd_addr_i[OFF_W +: T1_IDX_W];

  logic              rd_valid [NTAB];
  logic [ADDR_W-1:0] rd_tag   [NTAB];
  logic [LEN_W-1:0]  rd_len   [NTAB];
  logic [TYPE_W-1:0] rd_type  [NTAB];
  logic [ADDR_W-1:0] rd_next  [NTAB];
  logic              up_valid [NTAB];
  logic [ADDR_W-1:0] up_tag   [NTAB];
  logic [LEN_W-1:0]  up_len   [NTAB];
  logic [TYPE_W-1:0] up_type  [NTAB];
  logic [ADDR_W-1:0] up_next  [NTAB];
  ctr_t              up_ctr   [NTAB];
  logic              wr_en    [NTAB];
  logic [LEN_W-1:0]  wr_len   [NTAB];
  logic [TYPE_W-1:0] wr_type  [NTAB];
  logic [ADDR_W-1:0] wr_next  [NTAB];
  ctr_t              wr_ctr   [NTAB];

  for (genvar g = 0; g < NTAB; g++) begin : g_tab
    localparam int IW = (g == 0) ? T1_IDX_W : T2_IDX_W;
    logic [IW-1:0] rd_idx, up_idx;
    if (g == 0) begin : g_addr_idx
      assign rd_idx = lk_idx1;
      assign up_idx = up_idx1;
    end else begin : g_path_idx
      assign rd_idx = lk_hash_i;
      assign up_idx = upd_hash_i;
    end

    stream_pred_table #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TYPE_W(TYPE_W), .IDX_W(IW)
    ) u_tab (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_idx_i   (rd_idx),
      .rd_valid_o (rd_valid[g]),
      .rd_tag_o   (rd_tag[g]),
      .rd_len_o   (rd_len[g]),
      .rd_type_o  (rd_type[g]),
      .rd_next_o  (rd_next[g]),
      .up_idx_i   (up_idx),
      .up_valid_o (up_valid[g]),
      .up_tag_o   (up_tag[g]),
      .up_len_o   (up_len[g]),
      .up_type_o  (up_type[g]),
      .up_next_o  (up_next[g]),
      .up_ctr_o   (up_ctr[g]),
      .wr_en_i    (wr_en[g]),
      .wr_tag_i   (upd_addr_i),
      .wr_len_i   (wr_len[g]),
      .wr_type_i  (wr_type[g]),
      .wr_next_i  (wr_next[g]),
      .wr_ctr_i   (wr_ctr[g])
    );
  end

  stream_pred_upd #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TYPE_W(TYPE_W), .NTAB(NTAB)
  ) u_upd (
    .valid_i    (upd_valid_i),
    .mispred_i  (upd_mispred_i),
    .addr_i     (upd_addr_i),
    .len_i      (upd_len_i),
    .type_i     (upd_type_i),
    .next_i     (upd_next_i),
    .st_valid_i (up_valid),
    .st_tag_i   (up_tag),
    .st_len_i   (up_len),
    .st_type_i  (up_type),
    .st_next_i  (up_next),
    .st_ctr_i   (up_ctr),
    .wr_en_o    (wr_en),
    .wr_len_o   (wr_len),
    .wr_type_o  (wr_type),
    .wr_next_o  (wr_next),
    .wr_ctr_o   (wr_ctr)
  );

  stream_pred_sel #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TYPE_W(TYPE_W)
  ) u_sel (
    .addr_i    (lk_addr_i),
    .a_valid_i (rd_valid[0]),
    .a_tag_i   (rd_tag[0]),
    .a_len_i   (rd_len[0]),
    .a_type_i  (rd_type[0]),
    .a_next_i  (rd_next[0]),
    .p_valid_i (rd_valid[1]),
    .p_tag_i   (rd_tag[1]),
    .p_len_i   (rd_len[1]),
    .p_type_i  (rd_type[1]),
    .p_next_i  (rd_next[1]),
    .hit_o     (pred_hit_o),
    .src_o     (pred_src_o),
    .len_o     (pred_len_o),
    .type_o    (pred_type_o),
    .next_o    (pred_next_o)
  );
endmodule

// File: rtl/stream_pred_chk.sv
module stream_pred_chk #(
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 6,
  parameter int TYPE_W   = 2,
  parameter int T2_IDX_W = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   lk_addr_i,
  input logic [T2_IDX_W-1:0] lk_hash_i,
  input logic                pred_hit_o,
  input logic                pred_src_o,
  input logic [LEN_W-1:0]    pred_len_o,
  input logic [TYPE_W-1:0]   pred_type_o,
  input logic [ADDR_W-1:0]   pred_next_o,
  input logic                upd_valid_i,
  input logic [ADDR_W-1:0]   upd_addr_i,
  input logic [T2_IDX_W-1:0] upd_hash_i,
  input logic [LEN_W-1:0]    upd_len_i,
  input logic [TYPE_W-1:0]   upd_type_i,
  input logic [ADDR_W-1:0]   upd_next_i,
  input logic                upd_mispred_i
);
  logic same_lk;
  assign same_lk = upd_valid_i && (lk_addr_i == upd_addr_i) && (lk_hash_i == upd_hash_i);

  // R2
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> (pred_len_o == '0 && pred_type_o == '0 && pred_next_o == '0));

  // R4
  src_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_src_o |-> pred_hit_o);

  // R3
  alloc_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_lk && !pred_hit_o) |=>
      (!($stable(lk_addr_i) && $stable(lk_hash_i)) ||
       (pred_hit_o && pred_src_o && pred_len_o == $past(upd_len_i) &&
        pred_next_o == $past(upd_next_i))));

  // R6
  agree_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_lk && pred_hit_o && pred_len_o == upd_len_i && pred_next_o == upd_next_i) |=>
      (!($stable(lk_addr_i) && $stable(lk_hash_i)) ||
       (pred_hit_o && $stable(pred_len_o) && $stable(pred_next_o))));

  // R10
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=>
      (!($stable(lk_addr_i) && $stable(lk_hash_i)) ||
       ($stable(pred_hit_o) && $stable(pred_src_o) && $stable(pred_len_o) &&
        $stable(pred_type_o) && $stable(pred_next_o))));
endmodule

bind stream_pred stream_pred_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TYPE_W(TYPE_W), .T2_IDX_W(T2_IDX_W)
) u_chk (.*);

// File: tb/tb_stream_pred.sv
module tb_stream_pred;
  localparam int ADDR_W = 32, LEN_W = 6, TYPE_W = 2, HW = 6;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] lk_addr_i = '0;
  logic [HW-1:0]     lk_hash_i = '0;
  logic              pred_hit_o, pred_src_o;
  logic [LEN_W-1:0]  pred_len_o;
  logic [TYPE_W-1:0] pred_type_o;
  logic [ADDR_W-1:0] pred_next_o;
  logic              upd_valid_i = 1'b0;
  logic [ADDR_W-1:0] upd_addr_i = '0;
  logic [HW-1:0]     upd_hash_i = '0;
  logic [LEN_W-1:0]  upd_len_i = '0;
  logic [TYPE_W-1:0] upd_type_i = '0;
  logic [ADDR_W-1:0] upd_next_i = '0;
  logic              upd_mispred_i = 1'b0;

  int errors = 0, checks = 0;

  always #2 clk_i = ~clk_i;

  stream_pred dut (.*);

  // A and B share address-table slot 0 (index = addr[7:2])
  localparam logic [ADDR_W-1:0] A = 32'h0000_1000, B = 32'h0000_2000;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    upd_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic upd(input logic [ADDR_W-1:0] a, input logic [HW-1:0] h,
                     input int len, input int typ, input logic [ADDR_W-1:0] nx,
                     input logic mp);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_addr_i = a; upd_hash_i = h;
    upd_len_i = LEN_W'(len); upd_type_i = TYPE_W'(typ); upd_next_i = nx;
    upd_mispred_i = mp;
    @(negedge clk_i);
    upd_valid_i = 1'b0;
  endtask

  task automatic look(input logic [ADDR_W-1:0] a, input logic [HW-1:0] h);
    lk_addr_i = a; lk_hash_i = h;
    #1;
  endtask

  task automatic expect_pred(input string req, input logic hit, input logic src,
                             input int len, input int typ, input logic [ADDR_W-1:0] nx);
    check({req, " hit"}, 64'(pred_hit_o), 64'(hit));
    check({req, " src"}, 64'(pred_src_o), 64'(src));
    check({req, " len"}, 64'(pred_len_o), 64'(len));
    check({req, " type"}, 64'(pred_type_o), 64'(typ));
    check({req, " next"}, 64'(pred_next_o), 64'(nx));
  endtask

  task automatic t_reset();
    do_reset();
    look(A, 3);
    expect_pred("R1 reset empty", 0, 0, 0, 0, 0);
    look(B, 0);
    expect_pred("R2 miss zeros", 0, 0, 0, 0, 0);
  endtask

  task automatic t_alloc();
    do_reset();
    upd(A, 3, 7, 2, 32'h3000, 0);
    look(A, 3);
    expect_pred("R3 alloc both / R4 path wins", 1, 1, 7, 2, 32'h3000);
    look(A, 5);
    expect_pred("R4 address table only", 1, 0, 7, 2, 32'h3000);
    look(B, 5);
    expect_pred("R5 tag mismatch addr slot", 0, 0, 0, 0, 0);
    look(B, 3);
    expect_pred("R5 tag mismatch path slot", 0, 0, 0, 0, 0);
  endtask

  task automatic t_hyst();
    do_reset();
    upd(A, 3, 7, 2, 32'h3000, 0);
    upd(A, 3, 9, 1, 32'h4000, 0);          // ctr 1 -> replaced
    look(A, 3);
    expect_pred("R6 replace at ctr1", 1, 1, 9, 1, 32'h4000);
    for (int i = 0; i < 5; i++) upd(A, 3, 9, 1, 32'h4000, 0);  // saturate at 3
    upd(A, 3, 4, 3, 32'h5000, 0);
    look(A, 3);
    expect_pred("R6 first disagree keeps", 1, 1, 9, 1, 32'h4000);
    upd(A, 3, 4, 3, 32'h5000, 0);
    look(A, 3);
    expect_pred("R6 second disagree keeps", 1, 1, 9, 1, 32'h4000);
    upd(A, 3, 4, 3, 32'h5000, 0);
    look(A, 3);
    expect_pred("R6 third disagree replaces", 1, 1, 4, 3, 32'h5000);
    look(A, 9);
    expect_pred("R6 addr table same", 1, 0, 4, 3, 32'h5000);
  endtask

  task automatic t_path_only();
    do_reset();
    upd(A, 3, 5, 1, 32'h6000, 0);
    upd(B, 5, 6, 2, 32'h7000, 0);          // evicts A from addr slot 0
    upd(A, 3, 8, 3, 32'h8000, 0);          // path-only hit, ctr1 -> replace
    look(A, 3);
    expect_pred("R7 path entry trained", 1, 1, 8, 3, 32'h8000);
    look(B, 7);
    expect_pred("R7 addr slot keeps B", 1, 0, 6, 2, 32'h7000);
    look(A, 7);
    expect_pred("R7 A absent from addr table", 0, 0, 0, 0, 0);
  endtask

  task automatic t_mispred_alloc();
    do_reset();
    upd(A, 3, 5, 1, 32'h6000, 0);
    upd(A, 5, 5, 1, 32'h6000, 0);          // addr-only hit, no mispredict
    look(A, 5);
    expect_pred("R8 no alloc without mispredict", 1, 0, 5, 1, 32'h6000);
    upd(A, 5, 3, 2, 32'h9000, 1);          // addr ctr 2 -> 1 keeps; path alloc
    look(A, 5);
    expect_pred("R8 path alloc on mispredict", 1, 1, 3, 2, 32'h9000);
    look(A, 9);
    expect_pred("R8 addr table kept", 1, 0, 5, 1, 32'h6000);
  endtask

  task automatic t_same_cycle();
    do_reset();
    upd(A, 3, 5, 1, 32'h6000, 0);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_addr_i = A; upd_hash_i = 3;
    upd_len_i = 9; upd_type_i = 2; upd_next_i = 32'hA000; upd_mispred_i = 1'b0;
    look(A, 3);
    expect_pred("R9 pre-update contents", 1, 1, 5, 1, 32'h6000);
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    #1;
    expect_pred("R9 post-edge contents", 1, 1, 9, 2, 32'hA000);
  endtask

  task automatic t_idle();
    do_reset();
    @(negedge clk_i);
    upd_valid_i = 1'b0; upd_addr_i = A; upd_hash_i = 3;
    upd_len_i = 7; upd_type_i = 1; upd_next_i = 32'h3000;
    repeat (3) @(negedge clk_i);
    look(A, 3);
    expect_pred("R10 update ignored when idle", 0, 0, 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_alloc();
        t_hyst();
        t_path_only();
        t_mispred_alloc();
        t_same_cycle();
        t_idle();
      end
      begin
        repeat (20000) @(posedge clk_i);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule